// File: doc/BRIEF.md
# NAND Tree Connectivity Test Sequencer

This block sits on the board side of a device that has been placed in its chained-NAND test mode. It drives every tree input of the device from one parallel vector and reads back the single tree output through a two-flop synchronizer. It then finds out which input pins are not properly connected to the board.

A run begins on a start pulse. The sequencer holds every tree input high and confirms that the output reads high. If it does not, the sequencer flags a baseline fault and ends the run without stepping any input. Otherwise it pulls the inputs low one at a time, in a fixed order, and keeps every earlier input low. After each change it waits a programmable settle time and compares the synchronized output with a reference level that toggles on every step. When a pin fails to toggle the output, its bit is set in a fault bitmap. The reference then follows the level actually observed, so a single open pin does not cause every later pin to be flagged. At the end of a run the block gives a one-cycle done pulse and a pass flag.

Top module: `nand_tree_seq`

## Requirements
- R1: After reset, and whenever no run is active, all bits of `tree_in_o` are 1. After reset, `fault_o` is 0 and `busy_o`, `done_o`, `pass_o` and `baseline_fault_o` are 0.
- R2: A start pulse received while idle sets `busy_o` in the next cycle. The all-high baseline is then sampled. If the sampled level is 0, `baseline_fault_o` is set, no input is driven low, and `done_o` rises exactly settle+3 cycles after the start edge.
- R3: Each step drives exactly one more input low. Bit 0 goes first and bit N_PINS-1 goes last, and every earlier bit stays low. A run with a good baseline makes exactly N_PINS such steps.
- R4: Every check phase (the baseline check and each step) lasts settle_cycles_i+3 clock cycles. A full run therefore asserts `done_o` (N_PINS+1)*(settle_cycles_i+3) cycles after the start edge.
- R5: On a fault-free device, the expected level after step k is 0 for odd k and 1 for even k. Such a device yields `fault_o`=0 and `pass_o`=1.
- R6: If the output does not reach the expected level after step k, bit k-1 of `fault_o` is set.
- R7: After a mismatch, the next expected level is the inverse of the level observed. Only the pins that fail to toggle are flagged, including adjacent ones and the first and last pins.
- R8: `done_o` is high for exactly one cycle. `pass_o` is 1 only when `fault_o` is 0 and `baseline_fault_o` is 0. Results hold until the next start.
- R9: A start pulse received during a run has no effect on its timing or results.
- R10: A new start clears `fault_o` and `baseline_fault_o` from the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| settle_cycles_i | input | SETTLE_W | Extra wait cycles before each sample |
| tree_out_i | input | 1 | Tree output from the device (asynchronous) |
| tree_in_o | output | N_PINS | Drive for the tree inputs, bit 0 stepped first |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Last run found no fault |
| baseline_fault_o | output | 1 | All-high check failed on last run |
| fault_o | output | N_PINS | Per-pin fault bitmap of last run |

## Verification
The hardest behaviour to reach from the ports is reference resynchronization after a missed toggle. It is only visible when a faulty pin is followed by good pins, and it matters most when faulty pins sit next to each other or at the ends of the order. The bench contains a device model whose output is high when an even number of inputs are seen low. Per-pin stuck-high and stuck-low masks are placed in the model, so that stuck-high pins give missed toggles and a stuck-low pin breaks the baseline. The bench then checks that the bitmap equals the stuck mask exactly. A start pulse injected in the middle of a run, and runs with different settle values, check the timing.

// File: rtl/nt_pkg.sv
`timescale 1ns/1ps
package nt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BASE = 2'd1,
    ST_STEP = 2'd2,
    ST_DONE = 2'd3
  } nt_state_e;
endpackage

// File: rtl/nt_sync.sv
`timescale 1ns/1ps
module nt_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/nt_settle.sv
`timescale 1ns/1ps
module nt_settle #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/nand_tree_seq.sv
`timescale 1ns/1ps
module nand_tree_seq
  import nt_pkg::*;
#(
  parameter int unsigned N_PINS      = 17,
  parameter int unsigned SETTLE_W    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  input  logic                tree_out_i,
  output logic [N_PINS-1:0]   tree_in_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                pass_o,
  output logic                baseline_fault_o,
  output logic [N_PINS-1:0]   fault_o
);
  localparam int unsigned CNT_W = SETTLE_W + 2;

  nt_state_e         state_q;
  logic [N_PINS-1:0] low_q;     // cumulative mask of inputs held low
  logic [N_PINS-1:0] fault_q;
  logic [N_PINS-1:0] newest;
  logic              base_q, ran_q, exp_q;
  logic              obs, tmr_exp, act, tmr_load;
  logic [CNT_W-1:0]  tmr_val;

  nt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (tree_out_i),
    .q_o   (obs)
  );

  // wait covers settle time plus synchronizer latency
  assign tmr_val  = CNT_W'(settle_cycles_i) + CNT_W'(SYNC_STAGES);
  assign act      = tmr_exp && ((state_q == ST_BASE) || (state_q == ST_STEP));
  assign tmr_load = ((state_q == ST_IDLE) && start_i) || act;
  assign newest   = low_q & ~(low_q >> 1);

  nt_settle #(.CNT_W(CNT_W)) u_settle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .expired_o (tmr_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      low_q   <= '0;
      fault_q <= '0;
      base_q  <= 1'b0;
      ran_q   <= 1'b0;
      exp_q   <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          low_q <= '0;
          if (start_i) begin
            fault_q <= '0;
            base_q  <= 1'b0;
            ran_q   <= 1'b0;
            state_q <= ST_BASE;
          end
        end
        ST_BASE: if (act) begin
          if (obs) begin
            low_q   <= {{(N_PINS-1){1'b0}}, 1'b1};
            exp_q   <= 1'b0;
            state_q <= ST_STEP;
          end else begin
            base_q  <= 1'b1;
            ran_q   <= 1'b1;
            state_q <= ST_DONE;
          end
        end
        ST_STEP: if (act) begin
          if (obs != exp_q) fault_q <= fault_q | newest;
          if (low_q[N_PINS-1]) begin
            ran_q   <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            low_q <= {low_q[N_PINS-2:0], 1'b1};
            exp_q <= ~obs;  // track observed level, not a fixed parity
          end
        end
        ST_DONE: begin
          low_q   <= '0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tree_in_o        = ~low_q;
  assign busy_o           = (state_q == ST_BASE) || (state_q == ST_STEP);
  assign done_o           = (state_q == ST_DONE);
  assign baseline_fault_o = base_q;
  assign fault_o          = fault_q;
  assign pass_o           = ran_q && !busy_o && !base_q && (fault_q == '0);
endmodule

// File: rtl/nand_tree_seq_chk.sv
`timescale 1ns/1ps
module nand_tree_seq_chk #(
  parameter int unsigned N_PINS = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [N_PINS-1:0] tree_in_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              pass_o,
  input logic              baseline_fault_o,
  input logic [N_PINS-1:0] fault_o
);
  p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !done_o) |-> (&tree_in_o));

  p_abort_no_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baseline_fault_o |-> (&tree_in_o));

  p_one_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && (tree_in_o != $past(tree_in_o))) |->
      ($countones($past(tree_in_o)) == $countones(tree_in_o) + 1));

  p_monotone_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ((tree_in_o & ~$past(tree_in_o)) == '0));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_pass_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> ((fault_o == '0) && !baseline_fault_o && !busy_o));

  p_busy_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

  p_result_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(fault_o) && $stable(baseline_fault_o)));
endmodule

bind nand_tree_seq nand_tree_seq_chk #(.N_PINS(N_PINS)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .start_i         (start_i),
  .tree_in_o       (tree_in_o),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .pass_o          (pass_o),
  .baseline_fault_o(baseline_fault_o),
  .fault_o         (fault_o)
);

// File: tb/tb_nand_tree_seq.sv
`timescale 1ns/1ps
module tb_nand_tree_seq;
  localparam int N = 17;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [SW-1:0] settle = '0;
  logic          tree_out;
  logic [N-1:0]  tree_in, fault;
  logic          busy, done, pass, base;
  logic [N-1:0]  stuck_hi = '0, stuck_lo = '0;
  logic [N-1:0]  eff_low;
  int total = 0, bad = 0;
  int steps = 0, mono_err = 0;
  logic [N-1:0]  prev_in = '1;

  always #4 clk = ~clk;

  // device model: output high when an even number of pins are seen low
  assign eff_low  = (~tree_in | stuck_lo) & ~stuck_hi;
  assign tree_out = ~(^eff_low);

  nand_tree_seq #(.N_PINS(N), .SETTLE_W(SW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .settle_cycles_i(settle),
    .tree_out_i(tree_out), .tree_in_o(tree_in), .busy_o(busy), .done_o(done),
    .pass_o(pass), .baseline_fault_o(base), .fault_o(fault)
  );

  // step monitor for R3: each change clears the lowest remaining high bit
  always @(negedge clk) begin
    if (rst_n && busy && tree_in != prev_in) begin
      steps++;
      if (tree_in !== (prev_in & (prev_in - 1'b1))) mono_err++;
    end
    prev_in = tree_in;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run(input string tag, input int st, input logic [N-1:0] shi,
                     input logic [N-1:0] slo, input bit poke);
    int cyc;
    int exp_cyc;
    bit exp_base;
    logic [N-1:0] exp_fault;
    exp_base  = ((^slo) == 1'b1);
    exp_fault = exp_base ? '0 : shi;
    exp_cyc   = exp_base ? (st + 3) : (N + 1) * (st + 3);
    @(negedge clk);
    settle = SW'(st); stuck_hi = shi; stuck_lo = slo;
    steps = 0; mono_err = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    chk({tag, " R2 busy after start"}, 32'(busy), 32'd1);
    chk({tag, " R10 bitmap cleared"}, 32'(fault | N'(base)), 32'd0);
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 10) start = 1'b1;
      else start = 1'b0;
    end
    chk({tag, " R4 run length"}, 32'(cyc), 32'(exp_cyc));
    chk({tag, " R6 R7 fault bitmap"}, 32'(fault), 32'(exp_fault));
    chk({tag, " R2 baseline flag"}, 32'(base), 32'(exp_base));
    chk({tag, " R8 pass at done"}, 32'(pass), 32'(!exp_base && exp_fault == '0));
    chk({tag, " R3 step count"}, 32'(steps), exp_base ? 32'd0 : 32'(N));
    chk({tag, " R3 step order"}, 32'(mono_err), 32'd0);
    @(negedge clk);
    chk({tag, " R8 done single cycle"}, 32'(done), 32'd0);
    chk({tag, " R1 idle inputs high"}, 32'(tree_in), 32'((1 << N) - 1));
    chk({tag, " R8 pass held"}, 32'(pass), 32'(!exp_base && exp_fault == '0));
    stuck_hi = '0; stuck_lo = '0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset inputs high", 32'(tree_in), 32'((1 << N) - 1));
    chk("R1 reset outputs", {27'd0, busy, done, pass, base, |fault}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 32'(busy | done), 32'd0);
  endtask

  task automatic t_good();      run("good R5", 3, '0, '0, 1'b0); endtask
  task automatic t_one_bad();   run("single R6", 2, N'(1) << 4, '0, 1'b0); endtask
  task automatic t_multi_bad(); run("multi R7", 1, (N'(1) << 0) | (N'(1) << 7) | (N'(1) << 8) | (N'(1) << 16), '0, 1'b0); endtask
  task automatic t_regood();    run("rerun R10", 0, '0, '0, 1'b0); endtask
  task automatic t_baseline();  run("baseline R2", 0, '0, N'(1) << 3, 1'b0); endtask
  task automatic t_slow();      run("settle R4", 10, N'(1) << 12, '0, 1'b0); endtask
  task automatic t_poke();      run("poke R9", 4, N'(1) << 9, '0, 1'b1); endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_good();
    t_one_bad();
    t_multi_bad();
    t_regood();
    t_baseline();
    t_slow();
    t_poke();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule